// File: doc/BRIEF.md
# Triggered Multi-Channel Pulse Delay Generator

The block waits for an edge on an asynchronous trigger line and, once it sees the chosen edge, starts one shared tick counter. The counter runs from zero up to a programmable total count and then stops, which ends the cycle. Several output channels derive their pulses from that one counter. Each channel holds two 32-bit values and compares them against the count.

In two-timer mode a channel has two threshold timers. Each timer turns true once the count exceeds its value, and the pulse is the exclusive OR of the two timers. In window mode the second value is a duration: the pulse is active while the count lies above the delay and at or below delay plus duration. Any channel can be inverted, so that it idles high and goes low while active.

Each channel drives a group of identical output lines, which lets one timed pulse feed several pins. A typical setup uses a 40 MHz tick with a total count of 400000 to match a 100 Hz trigger. All settings are captured when a trigger is accepted, so changing them during a cycle has no effect on that cycle.

Top module: `pulse_delay_gen`

## Requirements
- R1: While `rst` is high, `triggered` is 0 and every output line sits at its channel's idle level. The idle level is 0, or 1 when that channel's `invert` bit is 1.
- R2: `edge_sel` = 1 accepts a 0-to-1 change of `trig_in` and `edge_sel` = 0 accepts a 1-to-0 change. A change in the other direction starts no cycle, and `triggered` stays 0.
- R3: `trig_in` passes through two synchronizing flops and one history flop. If `trig_in` changes shortly after a rising clock edge, `triggered` is 1 after the third rising clock edge that follows, and the count starts at 0 in that cycle.
- R4: `triggered` stays high for `total_cnt`+1 cycles, while the count steps through 0 to `total_cnt`, and then falls.
- R5: When `win_mode` bit c is 0, channel c is active in the output cycle that follows a count value k if exactly one of k > A and k > B holds. A is `delay_a[c*32 +: 32]` and B is `delay_b[c*32 +: 32]`. As a result the pulse starts A+2 cycles after `triggered` rises and lasts B−A cycles.
- R6: When `win_mode` bit c is 1, channel c is active in the output cycle that follows a count value k when A < k ≤ A+B. B is the duration, and a duration of 0 gives no pulse.
- R7: When `invert` bit c is 1, channel c's lines are 1 while idle and 0 while active.
- R8: Channel c drives lines `pulse_out[c*FAN +: FAN]`, and all lines of a group carry the same value.
- R9: A trigger edge that arrives while `triggered` is high is ignored. The running cycle keeps its timing, and no new cycle follows it.
- R10: Changes to delays, modes, polarity or `total_cnt` while a cycle runs do not alter that cycle. They take effect from the next accepted trigger. After the cycle ends, the idle level follows the live `invert` bit.
- R11: Activity past the total count is cut off. Outputs return to their idle level one cycle after `triggered` falls, and a threshold at or above `total_cnt` never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger line |
| edge_sel | input | 1 | 1 = rising trigger edge, 0 = falling |
| total_cnt | input | CW | Last count value of a cycle |
| delay_a | input | NCH*CW | Per-channel first threshold / window start |
| delay_b | input | NCH*CW | Per-channel second threshold / window duration |
| win_mode | input | NCH | Per-channel 1 = window mode, 0 = two-timer mode |
| invert | input | NCH | Per-channel output polarity inversion |
| pulse_out | output | NCH*FAN | Fanned-out pulse lines, FAN per channel |
| triggered | output | 1 | High while a triggered cycle runs |

## Verification
Every pair of thresholds from 0 to 5 is swept against a short total count. One channel in each of the four mode and polarity combinations runs in every pass. This separates an ordered pair from a reversed pair, equal thresholds from a zero-width window, and thresholds from clipping at the total count. Several directed cycles cover the rest. They send opposite-direction edges to show that the edge selection really filters, apply toggles during a cycle to show that retriggering is locked out, and apply a mid-cycle reconfiguration to show the latch boundary. A total count of zero checks the shortest possible cycle.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_e;

  typedef struct packed {
    logic win;
    logic inv;
  } ch_mode_t;
endpackage

// File: rtl/pdg_trig_detect.sv
module pdg_trig_detect
  import pdg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  trig_in,
  input  edge_e edge_mode,
  output logic  edge_hit
);
  localparam int FILL_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic [FILL_W-1:0]      fill_q;
  logic                   cur_lvl;

  assign cur_lvl = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= trig_in;
      end
    end
  endgenerate

  // history flop and a fill marker that blocks edges until the chain holds real samples
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      fill_q <= '0;
    end else begin
      hist_q <= cur_lvl;
      fill_q <= {fill_q[FILL_W-2:0], 1'b1};
    end
  end

  always_comb begin
    if (!fill_q[FILL_W-1])            edge_hit = 1'b0;
    else if (edge_mode == EDGE_RISE)  edge_hit = cur_lvl > hist_q;
    else                              edge_hit = cur_lvl < hist_q;
  end
endmodule

// File: rtl/pdg_tick_counter.sv
module pdg_tick_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] total_in,
  output logic          running,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] total_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      total_q <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        total_q <= total_in;
      end
    end else if (cnt == total_q) begin
      running <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdg_channel.sv
module pdg_channel
  import pdg_pkg::*;
#(
  parameter int CW  = 32,
  parameter int FAN = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           running,
  input  logic [CW-1:0]  cnt,
  input  logic [CW-1:0]  thr_a_in,
  input  logic [CW-1:0]  thr_b_in,
  input  ch_mode_t       mode_in,
  output logic [FAN-1:0] lines
);
  localparam int EW = CW + 1;

  logic [CW-1:0] thr_a_q, thr_b_q;
  ch_mode_t      mode_q;
  logic [EW-1:0] win_end;
  logic          tmr_a, tmr_b, active, pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_a_q <= '0;
      thr_b_q <= '0;
      mode_q  <= '0;
    end else if (load) begin
      thr_a_q <= thr_a_in;
      thr_b_q <= thr_b_in;
      mode_q  <= mode_in;
    end
  end

  // widened sum so that start + duration cannot wrap
  assign win_end = {1'b0, thr_a_q} + {1'b0, thr_b_q};

  always_comb begin
    tmr_a = cnt > thr_a_q;
    if (mode_q.win) tmr_b = {1'b0, cnt} > win_end;
    else            tmr_b = cnt > thr_b_q;
    active = running && (tmr_a ^ tmr_b);
    pol    = running ? mode_q.inv : mode_in.inv;
  end

  always_ff @(posedge clk) begin
    if (rst) lines <= {FAN{mode_in.inv}};
    else     lines <= {FAN{active ^ pol}};
  end
endmodule

// File: rtl/pulse_delay_gen.sv
module pulse_delay_gen
  import pdg_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CW          = 32,
  parameter int FAN         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_in,
  input  logic               edge_sel,
  input  logic [CW-1:0]      total_cnt,
  input  logic [NCH*CW-1:0]  delay_a,
  input  logic [NCH*CW-1:0]  delay_b,
  input  logic [NCH-1:0]     win_mode,
  input  logic [NCH-1:0]     invert,
  output logic [NCH*FAN-1:0] pulse_out,
  output logic               triggered
);
  logic          edge_hit, accept, running;
  logic [CW-1:0] cnt, total_q;

  pdg_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .trig_in   (trig_in),
    .edge_mode (edge_e'(edge_sel)),
    .edge_hit  (edge_hit)
  );

  assign accept = edge_hit && !running;

  pdg_tick_counter #(.CW(CW)) u_count (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .total_in (total_cnt),
    .running  (running),
    .cnt      (cnt),
    .total_q  (total_q)
  );

  assign triggered = running;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ch_mode_t md;
      assign md.win = win_mode[c];
      assign md.inv = invert[c];
      pdg_channel #(.CW(CW), .FAN(FAN)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .running  (running),
        .cnt      (cnt),
        .thr_a_in (delay_a[c*CW +: CW]),
        .thr_b_in (delay_b[c*CW +: CW]),
        .mode_in  (md),
        .lines    (pulse_out[c*FAN +: FAN])
      );
    end
  endgenerate
endmodule

// File: rtl/pdg_checker.sv
module pdg_checker #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int FAN = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               triggered,
  input logic [CW-1:0]      cnt,
  input logic [CW-1:0]      total_q,
  input logic [NCH-1:0]     invert,
  input logic [NCH*FAN-1:0] pulse_out
);
  logic [NCH*FAN-1:0] idle_pat;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < FAN; j++)
        idle_pat[c*FAN + j] = invert[c];
  end

  // R1 / R11: outside a cycle the lines settle to the live idle level
  p_idle_level_r11: assert property (@(posedge clk) disable iff (rst)
    !triggered |=> pulse_out == $past(idle_pat));

  // R3: every cycle begins at count zero
  p_start_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(triggered) |-> cnt == '0);

  // R4: the cycle keeps running below the total
  p_hold_run_r4: assert property (@(posedge clk) disable iff (rst)
    (triggered && cnt != total_q) |=> triggered);

  // R4: the cycle ends right after the total is reached
  p_stop_total_r4: assert property (@(posedge clk) disable iff (rst)
    (triggered && cnt == total_q) |=> !triggered);

  // R4: the count advances by one each running cycle
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (triggered && $past(triggered)) |-> cnt == $past(cnt) + 1'b1);

  // R10: captured total does not move during a cycle
  p_total_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (triggered && $past(triggered)) |-> $stable(total_q));
endmodule

bind pulse_delay_gen pdg_checker #(.NCH(NCH), .CW(CW), .FAN(FAN)) u_pdg_chk (
  .clk       (clk),
  .rst       (rst),
  .triggered (triggered),
  .cnt       (cnt),
  .total_q   (total_q),
  .invert    (invert),
  .pulse_out (pulse_out)
);

// File: tb/test_pulse_delay_gen.sv
module test_pulse_delay_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int FAN = 3;

  logic               clk = 1'b0;
  logic               rst;
  logic               trig_in;
  logic               edge_sel;
  logic [CW-1:0]      total_cnt;
  logic [NCH*CW-1:0]  delay_a, delay_b;
  logic [NCH-1:0]     win_mode, invert;
  logic [NCH*FAN-1:0] pulse_out;
  logic               triggered;

  int cfg_a [NCH];
  int cfg_b [NCH];
  int sa [NCH];
  int sb [NCH];
  logic [NCH-1:0] sw, si;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      delay_a[c*CW +: CW] = cfg_a[c];
      delay_b[c*CW +: CW] = cfg_b[c];
    end
  end

  pulse_delay_gen #(.NCH(NCH), .CW(CW), .FAN(FAN)) i_pulse_delay_gen (
    .clk(clk), .rst(rst), .trig_in(trig_in), .edge_sel(edge_sel),
    .total_cnt(total_cnt), .delay_a(delay_a), .delay_b(delay_b),
    .win_mode(win_mode), .invert(invert), .pulse_out(pulse_out),
    .triggered(triggered));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R8: every line of the group is compared with the one expected level
  task automatic check_lines(input string req, input int c, input logic lvl);
    for (int j = 0; j < FAN; j++)
      check(req, pulse_out[c*FAN + j], lvl);
  endtask

  // R1 R2: idle period, no cycle may start
  task automatic idle_check(input string req, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(req, triggered, 0);
      for (int c = 0; c < NCH; c++) check_lines(req, c, invert[c]);
    end
  endtask

  function automatic logic exp_level(input int c, input int n, input int total);
    int  m;
    logic act;
    m = n - 1;
    if (m < 0 || m > total) return invert[c];
    if (sw[c]) act = (m > sa[c]) && (m <= sa[c] + sb[c]);
    else       act = (m > sa[c]) != (m > sb[c]);
    return act ^ si[c];
  endfunction

  // drives the accepted edge at a falling clock edge, then follows the cycle
  task automatic run_cycle(input logic new_lvl, input int total,
                           input bit toggle, input bit reconfig);
    string tag;
    total_cnt = total;
    for (int c = 0; c < NCH; c++) begin
      sa[c] = cfg_a[c]; sb[c] = cfg_b[c];
    end
    sw = win_mode; si = invert;
    trig_in = new_lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 start", triggered, 1);
    for (int n = 0; n <= total + 3; n++) begin
      if (n > 0) @(negedge clk);
      check("R4 triggered span", triggered, (n <= total) ? 1 : 0);
      for (int c = 0; c < NCH; c++) begin
        tag = sw[c] ? "R6 window" : "R5 two-timer";
        if (si[c]) tag = {tag, " R7 invert"};
        if (n - 1 > total) tag = {tag, " R11 idle"};
        check_lines(tag, c, exp_level(c, n, total));
      end
      // R9: edges during the cycle
      if (toggle && (n == 5 || n == 7)) trig_in = ~trig_in;
      // R10: new settings while running
      if (reconfig && n == 3) begin
        for (int c = 0; c < NCH; c++) begin
          cfg_a[c] = 1; cfg_b[c] = 2;
        end
        win_mode  = ~win_mode;
        invert    = ~invert;
        total_cnt = 2;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; trig_in = 1'b0; edge_sel = 1'b1; total_cnt = 12;
    win_mode = '0; invert = 4'b0101;
    for (int c = 0; c < NCH; c++) begin cfg_a[c] = 0; cfg_b[c] = 0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset triggered", triggered, 0);
    for (int c = 0; c < NCH; c++) check_lines("R1 reset level", c, invert[c]);
    rst = 1'b0;
    idle_check("R1 idle after reset", 5);

    // two-timer mode: ordered, narrow, reversed, clipped by the total (R11)
    cfg_a = '{2, 0, 5, 4};
    cfg_b = '{6, 1, 3, 30};
    run_cycle(1'b1, 12, 1'b0, 1'b0);

    // R2: falling edge while rising is selected is ignored
    trig_in = 1'b0;
    idle_check("R2 wrong edge", 8);

    // R2: falling edge selected; rising change ignored, then a falling cycle
    edge_sel = 1'b0;
    trig_in  = 1'b1;
    idle_check("R2 wrong edge fall-mode", 8);
    win_mode = 4'b1111; invert = 4'b0011;
    cfg_a = '{1, 0, 6, 10};
    cfg_b = '{3, 0, 4, 5};
    run_cycle(1'b0, 14, 1'b1, 1'b0);
    // R9: no second cycle follows the ignored edges
    idle_check("R9 no retrigger", 6);

    // R10: mixed modes, settings changed mid-cycle
    edge_sel = 1'b1;
    win_mode = 4'b0101; invert = 4'b1000;
    cfg_a = '{0, 2, 3, 1};
    cfg_b = '{4, 3, 3, 6};
    run_cycle(1'b1, 9, 1'b0, 1'b1);
    idle_check("R10 idle uses live polarity", 3);

    // R4: total count of zero
    trig_in = 1'b0;
    idle_check("R2 wrong edge", 5);
    win_mode = 4'b0000; invert = 4'b0110;
    cfg_a = '{0, 0, 0, 0};
    cfg_b = '{0, 0, 0, 0};
    run_cycle(1'b1, 0, 1'b0, 1'b0);

    // sweep of threshold pairs over every mode/polarity combination
    win_mode = 4'b1010; invert = 4'b1100;
    for (int a = 0; a <= 5; a++) begin
      for (int b = 0; b <= 5; b++) begin
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
        cfg_a = '{a, a, b, a};
        cfg_b = '{b, b, a, b};
        run_cycle(1'b1, 6, 1'b0, 1'b0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule